// File: doc/BRIEF.md
# Oversampling Serial Receiver

This block recovers asynchronous serial characters from a single input line. A free-running oversample tick, supplied from outside (normally a baud divisor output), paces the receiver. Each bit on the line lasts a programmable number of ticks, so the bit rate is the module clock divided by both the divisor and that tick count. A synchronised copy of the line is watched for a falling level. The receiver then times each bit from that point and decides it by a three-sample majority vote taken at the bit centre.

A character of 8, 9 or 10 bits is moved into a holding register when its stop bit is decided, and a full flag is raised. The completed character may carry noise, framing or parity errors, and these are latched with it. A character that finishes while the holding register is still occupied is dropped and reported as an overrun. A separate counter raises an idle indication after one whole character time of unbroken high level. Software-side logic drains the block with a single-cycle read strobe, which releases the holding register and clears every flag.

Top module: `urx_core`

## Requirements
- R1: After reset, the data output is 0 and the full, overrun, noise, framing, parity and idle flags are all 0.
- R2: One bit lasts P = ratio+1 ticks; a ratio field below 3 acts as 3. The character length is 8 bits for format 0, 9 for format 1 and 10 for formats 2 and 3. Bits arrive least significant first into data[N-1:0], and the unused upper bits read 0.
- R3: The full flag rises on the cycle a character completes into an empty register. A read strobe clears full together with the noise, framing, parity, overrun and idle flags.
- R4: A start bit whose vote comes out high is discarded as a glitch. The receiver loads nothing and resumes hunting for the next falling level.
- R5: With h = P/2 (integer division), counting the tick that detected the start as tick 0 of the start bit, every bit is sampled at ticks h-1, h and h+1 of its period and takes the majority value. If the three samples of any start, data or stop bit disagree, noise is flagged with that character.
- R6: With parity enabled, the last of the N character bits is the parity bit. It is kept in the data register and checked: even mode (type 0) expects an even count of ones over all N bits, and odd mode (type 1) expects an odd count. A mismatch sets the parity flag. With parity disabled the flag stays 0.
- R7: A stop bit voted low sets the framing flag; the character is still loaded and full is raised.
- R8: A character that completes while full is set leaves the data and the other flags unchanged and sets the overrun flag.
- R9: Idle is flagged after T = (N+2)*P consecutive high ticks. With idle type 0 the count begins once the start bit of the last character has been accepted; with type 1 it begins after that character's stop bit. Idle is raised once per character and is cleared by a read.
- R10: While the enable input is 0, line activity is ignored: nothing is loaded and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-cycle oversample tick |
| rx_pin | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receiver enable |
| char_fmt | input | 2 | Character length select (0:8, 1:9, 2/3:10 bits) |
| par_en | input | 1 | Parity check enable |
| par_odd | input | 1 | Parity type, 1 = odd |
| os_ratio | input | 5 | Ticks per bit minus one |
| idle_from_stop | input | 1 | Idle count start: 0 after start bit, 1 after stop bit |
| rd_stb | input | 1 | Read strobe, clears full and flags |
| rx_data | output | 10 | Received character |
| data_full | output | 1 | Character waiting |
| err_overrun | output | 1 | Character lost while full |
| err_noise | output | 1 | Sample disagreement in the character |
| err_frame | output | 1 | Stop bit read low |
| err_parity | output | 1 | Parity mismatch |
| line_idle | output | 1 | Idle line detected |

## Verification
Several properties are checked on every cycle. When the register is empty, a completed character always raises full. An overrun never changes the stored data. A read leaves no flag standing. A parity error only appears with parity enabled. The enable input returns the sequencer to hunting, a glitched start bit always goes back to hunting, and the tick counter wraps at the bit length. The bench's scenarios are needed to show that the sample instants sit where R5 places them, that data lands in the right bit positions for every length and parity mode, that the ratio clamp works, and that the two idle counting origins give idle at different times.

// File: rtl/urx_pkg.sv
package urx_pkg;
  localparam int OSR_W    = 5;
  localparam int OSR_MIN  = 3;
  localparam int CHAR_MAX = 10;
  localparam int BCNT_W   = $clog2(CHAR_MAX + 1);
  localparam int IDLE_W   = $clog2((CHAR_MAX + 2) * (1 << OSR_W) + 1);

  typedef enum logic [1:0] {ST_HUNT, ST_START, ST_BITS, ST_STOP} rx_state_t;

  // ratio actually used: values below the minimum are raised to it
  function automatic logic [OSR_W-1:0] eff_ratio(input logic [OSR_W-1:0] r);
    return (r < OSR_W'(OSR_MIN)) ? OSR_W'(OSR_MIN) : r;
  endfunction

  // centre tick index of a bit lasting r+1 ticks
  function automatic logic [OSR_W-1:0] mid_tick(input logic [OSR_W-1:0] r);
    logic [OSR_W:0] t;
    t = {1'b0, r} + 1'b1;
    return t[OSR_W:1];
  endfunction

  function automatic logic [BCNT_W-1:0] char_bits(input logic [1:0] f);
    case (f)
      2'd0:    return BCNT_W'(8);
      2'd1:    return BCNT_W'(9);
      default: return BCNT_W'(10);
    endcase
  endfunction

  // one character time in ticks: start + N bits + stop
  function automatic logic [IDLE_W-1:0] frame_ticks(input logic [1:0] f,
                                                    input logic [OSR_W-1:0] r);
    logic [IDLE_W-1:0] nb, pt;
    nb = IDLE_W'(char_bits(f)) + IDLE_W'(2);
    pt = IDLE_W'(r) + IDLE_W'(1);
    return nb * pt;
  endfunction

  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

  function automatic logic disagree3(input logic [2:0] s);
    return !((s == 3'b000) || (s == 3'b111));
  endfunction
endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/urx_sampler.sv
module urx_sampler
  import urx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rx_s,
  input  logic             active,
  input  logic [OSR_W-1:0] ratio,
  output logic             vote_stb,
  output logic             vote,
  output logic             noisy
);
  logic [OSR_W-1:0] cnt, nxt, r_eff, half;
  logic             s_lo, s_mid;
  logic [2:0]       trio;

  assign r_eff = eff_ratio(ratio);
  assign half  = mid_tick(r_eff);
  assign nxt   = (cnt >= r_eff) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      s_lo  <= 1'b1;
      s_mid <= 1'b1;
    end else if (!active) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= nxt;
      if (nxt == half - 1'b1) s_lo  <= rx_s;
      if (nxt == half)        s_mid <= rx_s;
    end
  end

  assign trio     = {rx_s, s_mid, s_lo};
  assign vote_stb = active && tick && (nxt == half + 1'b1);
  assign vote     = maj3(trio);
  assign noisy    = disagree3(trio);

  // R2
  bit_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && tick && (cnt == r_eff) && $stable(ratio) |=> (cnt == '0));
endmodule

// File: rtl/urx_framer.sv
module urx_framer
  import urx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                rx_s,
  input  logic                rx_en,
  input  logic [1:0]          fmt,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                vote_stb,
  input  logic                vote,
  input  logic                noisy,
  output logic                busy,
  output logic                start_det,
  output logic                start_ok,
  output logic                char_done,
  output logic [CHAR_MAX-1:0] c_data,
  output logic                c_fe,
  output logic                c_pe,
  output logic                c_nf
);
  rx_state_t           st;
  logic [CHAR_MAX-1:0] shreg;
  logic [BCNT_W-1:0]   bitn, nbits;
  logic                nf_acc;

  assign nbits     = char_bits(fmt);
  assign busy      = (st != ST_HUNT);
  assign start_det = rx_en && (st == ST_HUNT) && tick && !rx_s;
  assign start_ok  = (st == ST_START) && vote_stb && !vote;
  assign char_done = (st == ST_STOP) && vote_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_HUNT;
      shreg  <= '0;
      bitn   <= '0;
      nf_acc <= 1'b0;
    end else if (!rx_en) begin
      st <= ST_HUNT;
    end else begin
      case (st)
        ST_HUNT: if (start_det) begin
          st     <= ST_START;
          shreg  <= '0;
          bitn   <= '0;
          nf_acc <= 1'b0;
        end
        ST_START: if (vote_stb) begin
          if (vote) st <= ST_HUNT;
          else begin
            st     <= ST_BITS;
            nf_acc <= noisy;
          end
        end
        ST_BITS: if (vote_stb) begin
          shreg[bitn] <= vote;
          nf_acc      <= nf_acc | noisy;
          if (bitn == nbits - 1'b1) st <= ST_STOP;
          else                      bitn <= bitn + 1'b1;
        end
        default: if (vote_stb) st <= ST_HUNT;
      endcase
    end
  end

  assign c_data = shreg;
  assign c_fe   = !vote;
  assign c_pe   = par_en && ((^shreg) != par_odd);
  assign c_nf   = nf_acc | noisy;

  // R10
  hunt_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (st == ST_HUNT));
  // R4
  glitch_rehunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_START) && vote_stb && vote && rx_en |=> (st == ST_HUNT) && !char_done);
endmodule

// File: rtl/urx_idle.sv
module urx_idle
  import urx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rx_s,
  input  logic             rx_en,
  input  logic             from_stop,
  input  logic [1:0]       fmt,
  input  logic [OSR_W-1:0] ratio,
  input  logic             start_det,
  input  logic             start_ok,
  input  logic             char_done,
  output logic             idle_set
);
  logic              armed;
  logic [IDLE_W-1:0] hcnt, limit;

  assign limit    = frame_ticks(fmt, eff_ratio(ratio));
  assign idle_set = armed && tick && rx_s && (hcnt == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      hcnt  <= '0;
    end else if (!rx_en || start_det) begin
      armed <= 1'b0;
      hcnt  <= '0;
    end else begin
      if (idle_set)                        armed <= 1'b0;
      else if (from_stop ? char_done : start_ok) armed <= 1'b1;
      if (!armed || idle_set)              hcnt <= '0;
      else if (tick)                       hcnt <= rx_s ? hcnt + 1'b1 : '0;
    end
  end

  // R9
  idle_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_set |=> !armed);
endmodule

// File: rtl/urx_core.sv
module urx_core
  import urx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rx_pin,
  input  logic       rx_en,
  input  logic [1:0] char_fmt,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic [4:0] os_ratio,
  input  logic       idle_from_stop,
  input  logic       rd_stb,
  output logic [9:0] rx_data,
  output logic       data_full,
  output logic       err_overrun,
  output logic       err_noise,
  output logic       err_frame,
  output logic       err_parity,
  output logic       line_idle
);
  logic                rx_s, busy, vote_stb, vote, noisy;
  logic                start_det, start_ok, char_done, idle_set;
  logic [CHAR_MAX-1:0] c_data;
  logic                c_fe, c_pe, c_nf;

  urx_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_pin), .q(rx_s));

  urx_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx_s(rx_s), .active(busy),
    .ratio(os_ratio), .vote_stb(vote_stb), .vote(vote), .noisy(noisy));

  urx_framer u_frm (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx_s(rx_s), .rx_en(rx_en),
    .fmt(char_fmt), .par_en(par_en), .par_odd(par_odd),
    .vote_stb(vote_stb), .vote(vote), .noisy(noisy), .busy(busy),
    .start_det(start_det), .start_ok(start_ok), .char_done(char_done),
    .c_data(c_data), .c_fe(c_fe), .c_pe(c_pe), .c_nf(c_nf));

  urx_idle u_idle (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx_s(rx_s), .rx_en(rx_en),
    .from_stop(idle_from_stop), .fmt(char_fmt), .ratio(os_ratio),
    .start_det(start_det), .start_ok(start_ok), .char_done(char_done),
    .idle_set(idle_set));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data     <= '0;
      data_full   <= 1'b0;
      err_overrun <= 1'b0;
      err_noise   <= 1'b0;
      err_frame   <= 1'b0;
      err_parity  <= 1'b0;
      line_idle   <= 1'b0;
    end else begin
      if (rd_stb) begin
        data_full   <= 1'b0;
        err_overrun <= 1'b0;
        err_noise   <= 1'b0;
        err_frame   <= 1'b0;
        err_parity  <= 1'b0;
        line_idle   <= 1'b0;
      end
      if (char_done) begin
        if (data_full && !rd_stb) begin
          err_overrun <= 1'b1;
        end else begin
          rx_data    <= c_data;
          data_full  <= 1'b1;
          err_frame  <= c_fe;
          err_parity <= c_pe;
          err_noise  <= c_nf;
        end
      end
      if (idle_set) line_idle <= 1'b1;
    end
  end

  // R3
  full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_done && !data_full |=> data_full);
  // R8
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_done && data_full && !rd_stb |=> err_overrun && $stable(rx_data) && $stable(err_frame));
  // R3
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && !char_done |=> !data_full && !err_overrun && !err_noise && !err_frame && !err_parity);
  // R6
  parity_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_parity) |-> $past(par_en));
endmodule

// File: tb/sim_urx_core.sv
module sim_urx_core;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic       clk = 1'b0, rst_n = 1'b0, os_tick = 1'b0, rx_pin = 1'b1, rx_en = 1'b0;
  logic       par_en = 1'b0, par_odd = 1'b0, idle_from_stop = 1'b0, rd_stb = 1'b0;
  logic [1:0] char_fmt = 2'd0;
  logic [4:0] os_ratio = 5'd15;
  logic [9:0] rx_data;
  logic       data_full, err_overrun, err_noise, err_frame, err_parity, line_idle;

  int n_chk = 0, n_err = 0, ph = 0;
  bit finished = 1'b0;

  urx_core u0 (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_pin(rx_pin), .rx_en(rx_en),
    .char_fmt(char_fmt), .par_en(par_en), .par_odd(par_odd), .os_ratio(os_ratio),
    .idle_from_stop(idle_from_stop), .rd_stb(rd_stb), .rx_data(rx_data),
    .data_full(data_full), .err_overrun(err_overrun), .err_noise(err_noise),
    .err_frame(err_frame), .err_parity(err_parity), .line_idle(line_idle));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    ph      <= (ph == TICK_DIV-1) ? 0 : ph + 1;
    os_tick <= (ph == TICK_DIV-2);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick_wait(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!os_tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic do_read();
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  function automatic int ticks_per_bit(input int r);
    return (r < 3) ? 4 : r + 1;
  endfunction

  function automatic int len_of(input int f);
    return (f == 0) ? 8 : (f == 1) ? 9 : 10;
  endfunction

  // character bits as they go on the line; pm 0 none, 1 even, 2 odd
  function automatic logic [9:0] make_char(input int d, input int nb, input int pm);
    logic [9:0] v;
    logic       p;
    v = 10'(d) & 10'((1 << nb) - 1);
    if (pm != 0) begin
      p = (pm == 2);
      for (int i = 0; i < nb - 1; i++) p = p ^ v[i];
      v[nb-1] = p;
    end
    return v;
  endfunction

  // bit index 0 = start, 1..nb = data, nb+1 = stop
  task automatic send_char(input logic [9:0] bits, input int nb, input int p,
                           input logic stop_lvl, input int nz_bit, input int nz_t);
    for (int b = 0; b < nb + 2; b++) begin
      logic lvl;
      lvl = (b == 0) ? 1'b0 : (b == nb + 1) ? stop_lvl : bits[b-1];
      for (int t = 0; t < p; t++) begin
        rx_pin = (b == nz_bit && t == nz_t) ? ~lvl : lvl;
        tick_wait(1);
      end
    end
    rx_pin = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int osr_l[4];
    int p, h;
    logic [9:0] v, a;
    osr_l = '{3, 5, 7, 15};

    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 data", rx_data, 0);
    chk("R1 full", data_full, 0);
    chk("R1 overrun", err_overrun, 0);
    chk("R1 noise", err_noise, 0);
    chk("R1 frame", err_frame, 0);
    chk("R1 parity", err_parity, 0);
    chk("R1 idle", line_idle, 0);
    rst_n = 1'b1;
    rx_en = 1'b1;
    tick_wait(3);

    // R2/R6 sweep over ratio, length, parity mode and data
    for (int oi = 0; oi < 4; oi++)
      for (int f = 0; f < 3; f++)
        for (int pm = 0; pm < 3; pm++)
          for (int k = 0; k < 3; k++) begin
            int d, nb;
            os_ratio = 5'(osr_l[oi]);
            char_fmt = 2'(f);
            par_en   = (pm != 0);
            par_odd  = (pm == 2);
            nb = len_of(f);
            d  = (osr_l[oi] * 37 + f * 91 + pm * 13 + k * 211 + 5) * 7;
            v  = make_char(d, nb, pm);
            p  = ticks_per_bit(osr_l[oi]);
            send_char(v, nb, p, 1'b1, -1, 0);
            chk("R2 data", rx_data, v);
            chk("R3 full set", data_full, 1);
            chk("R6 parity ok", err_parity, 0);
            chk("R7 frame ok", err_frame, 0);
            chk("R5 clean", err_noise, 0);
            do_read();
            chk("R3 full clear", data_full, 0);
            tick_wait(2);
          end

    // R6 parity mismatches
    os_ratio = 5'd3; char_fmt = 2'd0; par_en = 1'b1; par_odd = 1'b0; p = 4;
    v = make_char(8'h35, 8, 1) ^ 10'h080;
    send_char(v, 8, p, 1'b1, -1, 0);
    chk("R6 even mismatch", err_parity, 1);
    chk("R6 data kept", rx_data, v);
    do_read();
    chk("R3 parity cleared", err_parity, 0);
    par_odd = 1'b1;
    v = make_char(8'h6A, 8, 1);
    send_char(v, 8, p, 1'b1, -1, 0);
    chk("R6 odd mismatch", err_parity, 1);
    do_read();
    par_en = 1'b0;
    send_char(v ^ 10'h080, 8, p, 1'b1, -1, 0);
    chk("R6 disabled", err_parity, 0);
    do_read();
    tick_wait(2);

    // R7 framing
    send_char(10'h0C3, 8, p, 1'b0, -1, 0);
    chk("R7 frame set", err_frame, 1);
    chk("R7 loaded", data_full, 1);
    chk("R7 data", rx_data, 10'h0C3);
    do_read();
    chk("R3 frame cleared", err_frame, 0);
    tick_wait(4);

    // R5 sample positions and noise
    os_ratio = 5'd15; p = 16; h = 8;
    send_char(10'h0A5, 8, p, 1'b1, 3, h - 1);
    chk("R5 noise at h-1", err_noise, 1);
    chk("R5 vote data", rx_data, 10'h0A5);
    do_read();
    chk("R3 noise cleared", err_noise, 0);
    send_char(10'h05A, 8, p, 1'b1, 4, h + 2);
    chk("R5 outside window", err_noise, 0);
    do_read();
    send_char(10'h05A, 8, p, 1'b1, 2, 0);
    chk("R5 tick 0 ignored", err_noise, 0);
    do_read();
    send_char(10'h11E, 8, p, 1'b1, 9, h + 1);
    chk("R5 stop noise", err_noise, 1);
    chk("R5 stop data", rx_data, 10'h01E);
    do_read();
    send_char(10'h0F0, 8, p, 1'b1, 0, h);
    chk("R5 start noise", err_noise, 1);
    chk("R5 start data", rx_data, 10'h0F0);
    do_read();

    // R4 start glitch
    os_ratio = 5'd7; p = 8;
    rx_pin = 1'b0;
    tick_wait(2);
    rx_pin = 1'b1;
    tick_wait(20);
    chk("R4 glitch no load", data_full, 0);
    chk("R4 glitch no noise", err_noise, 0);
    send_char(10'h081, 8, p, 1'b1, -1, 0);
    chk("R4 resumes", rx_data, 10'h081);
    do_read();

    // R8 overrun
    os_ratio = 5'd3; p = 4;
    send_char(10'h011, 8, p, 1'b1, -1, 0);
    send_char(10'h022, 8, p, 1'b0, -1, 0);
    chk("R8 overrun", err_overrun, 1);
    chk("R8 data kept", rx_data, 10'h011);
    chk("R8 frame untouched", err_frame, 0);
    do_read();
    chk("R3 overrun cleared", err_overrun, 0);
    tick_wait(4);

    // R2 ratio clamp
    os_ratio = 5'd1;
    send_char(10'h0B7, 8, 4, 1'b1, -1, 0);
    chk("R2 clamp", rx_data, 10'h0B7);
    do_read();

    // R10 disabled receiver
    rx_en = 1'b0;
    send_char(10'h044, 8, 4, 1'b1, -1, 0);
    chk("R10 no load", data_full, 0);
    chk("R10 data", rx_data, 10'h0B7);
    rx_en = 1'b1;
    tick_wait(4);

    // R9 idle, origin after start bit
    os_ratio = 5'd3; char_fmt = 2'd0; idle_from_stop = 1'b0;
    send_char(10'h0FF, 8, 4, 1'b1, -1, 0);
    chk("R9 type0 not yet", line_idle, 0);
    tick_wait(10);
    chk("R9 type0 early", line_idle, 1);
    do_read();
    chk("R9 read clears", line_idle, 0);
    tick_wait(50);
    chk("R9 once per char", line_idle, 0);
    // R9 idle, origin after stop bit
    idle_from_stop = 1'b1;
    send_char(10'h0FF, 8, 4, 1'b1, -1, 0);
    tick_wait(10);
    chk("R9 type1 waits", line_idle, 0);
    tick_wait(35);
    chk("R9 type1 set", line_idle, 1);
    do_read();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule